// File: doc/BRIEF.md
# TMDS Symbol Encoder with DC Balance

This block turns one 8-bit pixel byte per clock into a 10-bit line symbol. A combinational first stage rewrites the byte as a chain of XOR or XNOR steps. It picks whichever chain gives fewer transitions, which makes a 9-bit intermediate word. A registered second stage keeps a signed count of how far the line has drifted toward ones or toward zeros. From that count it decides whether to invert the low eight bits of the intermediate word, so that the long-run mix of ones and zeros stays near even.

During blanking, video enable is low. The encoder then emits one of four fixed control symbols chosen by a 2-bit control word, and it clears the drift count. A synchronous reset clears the count and drives an all-zero symbol. Each symbol leaves the block exactly one clock after the inputs that produced it.

Top module: `tmds_symbol_encoder`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `sym_out` is 10'b0 after that edge, and the drift count is zero. Reset takes priority over the enable and control inputs.
- R2: The symbol for the inputs sampled at one rising edge appears on `sym_out` right after that edge (one cycle of latency), with no combinational path from input to output.
- R3: The first stage counts the ones in `pix_byte`. It uses the XNOR chain and a bit 8 of 0 when that count is above 4, or when it equals 4 and `pix_byte[0]` is 0. In every other case it uses the XOR chain and a bit 8 of 1. Bit 0 of the intermediate word always equals `pix_byte[0]`.
- R4: In a video symbol, `sym_out[8]` carries the intermediate bit 8, and `sym_out[9]`=1 means `sym_out[7:0]` holds the inverted low byte. Decoding a symbol therefore always gives back the original byte.
- R5: When the count is zero, or the intermediate low byte has exactly four ones, `sym_out[9]` is the complement of `sym_out[8]`. The low byte is inverted only when intermediate bit 8 is 0. The count then moves by (zeros−ones) of the low byte if bit 8 is 0, and by (ones−zeros) if bit 8 is 1.
- R6: In all other cases the low byte is inverted exactly when the count is positive and the low byte has more ones than zeros, or when the count is negative and the low byte has more zeros than ones. After an inversion the count moves by 2·bit8 + (zeros−ones). Otherwise it moves by (ones−zeros) − 2·(1−bit8).
- R7: The 5-bit two's-complement count always stays even and within −10..+10.
- R8: When `vid_en` is low, the count clears and `sym_out` is set by `ctl`: 00→10'b1101010100, 01→10'b0010101011, 10→10'b0101010100, 11→10'b1010101011.
- R9: From a count of −2, an intermediate word of 9'b1_0000_0101 (byte 8'h0F) gives the symbol 10'b11_1111_1010 and leaves a count of +4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_byte | input | 8 | Pixel byte to encode |
| ctl | input | 2 | Control word sent during blanking |
| vid_en | input | 1 | High: encode pixel byte; low: send control symbol |
| sym_out | output | 10 | Registered 10-bit line symbol |

## Verification
Reset, blanking and pixel encoding all write the same output and count registers, and reset and blanking can both be asserted in one cycle. The bench drives reset together with a low enable and a non-zero control word, and expects the all-zero symbol. It also drops reset and enable in the cycle after the count has built up. The next pixel is then checked against a model whose count has restarted at zero. Any carried-over drift shows up as a wrong symbol on the output.

// File: rtl/tmds_symbol_encoder.sv
module tmds_symbol_encoder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pix_byte,
  input  logic [1:0]        ctl,
  input  logic              vid_en,
  output logic [DATA_W+1:0] sym_out
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int TAL_W  = CNT_W + 1;
  localparam int HALF   = DATA_W / 2;

  logic [CNT_W-1:0]  n_in, n_qm;
  logic              use_xnor;
  logic [DATA_W:0]   qm;
  logic [TAL_W-1:0]  tally, tally_nx, diff, two_b8, two_nb8;
  logic [DATA_W+1:0] sym_nx, ctl_sym;
  logic              even_path, do_inv;

  always_comb begin
    n_in = '0;
    for (int i = 0; i < DATA_W; i++) n_in = n_in + CNT_W'(pix_byte[i]);
  end

  assign use_xnor = (n_in > CNT_W'(HALF)) || (n_in == CNT_W'(HALF) && !pix_byte[0]);

  always_comb begin
    logic [DATA_W:0] t;
    t = '0;
    t[0] = pix_byte[0];
    for (int i = 1; i < DATA_W; i++)
      t[i] = use_xnor ? ~(t[i-1] ^ pix_byte[i]) : (t[i-1] ^ pix_byte[i]);
    t[DATA_W] = ~use_xnor;
    qm = t;
  end

  always_comb begin
    n_qm = '0;
    for (int i = 0; i < DATA_W; i++) n_qm = n_qm + CNT_W'(qm[i]);
  end

  assign diff      = {n_qm, 1'b0} - TAL_W'(DATA_W);
  assign two_b8    = {{(TAL_W-2){1'b0}}, qm[DATA_W], 1'b0};
  assign two_nb8   = {{(TAL_W-2){1'b0}}, ~qm[DATA_W], 1'b0};
  assign even_path = (tally == '0) || (n_qm == CNT_W'(HALF));
  assign do_inv    = (!tally[TAL_W-1] && n_qm > CNT_W'(HALF)) ||
                     ( tally[TAL_W-1] && n_qm < CNT_W'(HALF));

  always_comb begin
    if (even_path) begin
      sym_nx   = {~qm[DATA_W], qm[DATA_W], qm[DATA_W] ? qm[DATA_W-1:0] : ~qm[DATA_W-1:0]};
      tally_nx = qm[DATA_W] ? tally + diff : tally - diff;
    end else if (do_inv) begin
      sym_nx   = {1'b1, qm[DATA_W], ~qm[DATA_W-1:0]};
      tally_nx = tally + two_b8 - diff;
    end else begin
      sym_nx   = {1'b0, qm[DATA_W], qm[DATA_W-1:0]};
      tally_nx = tally - two_nb8 + diff;
    end
  end

  always_comb begin
    case (ctl)
      2'b00:   ctl_sym = 10'b1101010100;
      2'b01:   ctl_sym = 10'b0010101011;
      2'b10:   ctl_sym = 10'b0101010100;
      default: ctl_sym = 10'b1010101011;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_out <= '0;
      tally   <= '0;
    end else if (!vid_en) begin
      sym_out <= ctl_sym;
      tally   <= '0;
    end else begin
      sym_out <= sym_nx;
      tally   <= tally_nx;
    end
  end

  function automatic logic [DATA_W-1:0] unpack(input logic [DATA_W+1:0] s);
    logic [DATA_W-1:0] q, d;
    q = s[DATA_W+1] ? ~s[DATA_W-1:0] : s[DATA_W-1:0];
    d[0] = q[0];
    for (int i = 1; i < DATA_W; i++)
      d[i] = s[DATA_W] ? (q[i] ^ q[i-1]) : ~(q[i] ^ q[i-1]);
    return d;
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sym_out == '0 && tally == '0));

  a_r4_lossless: assert property (@(posedge clk) disable iff (rst)
    ($past(vid_en) && !$past(rst)) |-> unpack(sym_out) == $past(pix_byte));

  a_r5_even_path_flag: assert property (@(posedge clk) disable iff (rst)
    ($past(vid_en) && !$past(rst) && $past(tally) == '0) |-> sym_out[DATA_W+1] != sym_out[DATA_W]);

  a_r7_tally_bounds: assert property (@(posedge clk) disable iff (rst)
    ($signed(tally) >= -TAL_W'(10) && $signed(tally) <= TAL_W'(10) && !tally[0]));

  a_r8_blank_symbol: assert property (@(posedge clk) disable iff (rst)
    (!$past(vid_en) && !$past(rst)) |-> (tally == '0 && sym_out[0] == $past(ctl[0]) &&
                                         sym_out[DATA_W+1] == ~^$past(ctl)));
endmodule

// File: tb/test_tmds_symbol_encoder.sv
`timescale 1ns/1ps
module test_tmds_symbol_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pix_byte = '0;
  logic [1:0] ctl = '0;
  logic       vid_en = 1'b0;
  logic [9:0] sym_out;

  int total = 0;
  int bad = 0;
  int mt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmds_symbol_encoder i_tmds_symbol_encoder (
    .clk(clk), .rst(rst), .pix_byte(pix_byte), .ctl(ctl), .vid_en(vid_en), .sym_out(sym_out)
  );

  function automatic logic [9:0] ctl_code(input logic [1:0] c);
    case (c)
      2'b00: return 10'b1101010100;
      2'b01: return 10'b0010101011;
      2'b10: return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [9:0] model_enc(input logic [7:0] b);
    int n, o, z;
    logic xn;
    logic [8:0] q;
    logic [9:0] e;
    n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    xn = (n > 4) || (n == 4 && b[0] == 1'b0);
    q[0] = b[0];
    for (int i = 1; i < 8; i++) q[i] = xn ? ~(q[i-1] ^ b[i]) : (q[i-1] ^ b[i]);
    q[8] = ~xn;
    o = 0;
    for (int i = 0; i < 8; i++) o += q[i];
    z = 8 - o;
    if (mt == 0 || o == z) begin
      e = {~q[8], q[8], q[8] ? q[7:0] : ~q[7:0]};
      mt += q[8] ? (o - z) : (z - o);
    end else if ((mt > 0 && o > z) || (mt < 0 && z > o)) begin
      e = {1'b1, q[8], ~q[7:0]};
      mt += 2 * int'(q[8]) + z - o;
    end else begin
      e = {1'b0, q[8], q[7:0]};
      mt += (o - z) - 2 * (1 - int'(q[8]));
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic [7:0] b, input logic [1:0] c, input bit en, input bit r,
                      input string req);
    logic [9:0] exp;
    pix_byte = b; ctl = c; vid_en = en; rst = r;
    if (r) begin exp = '0; mt = 0; end
    else if (!en) begin exp = ctl_code(c); mt = 0; end
    else exp = model_enc(b);
    @(posedge clk);
    @(negedge clk);
    check(req, sym_out, exp);
  endtask

  task automatic t_reset_state();
    step(8'hA5, 2'b11, 1'b1, 1'b1, "R1 reset output zero");
    step(8'h3C, 2'b10, 1'b0, 1'b1, "R1 reset beats blanking");
  endtask

  task automatic t_latency();
    step(8'h00, 2'b00, 1'b0, 1'b0, "R8 blank 00");
    pix_byte = 8'hFF; vid_en = 1'b1;
    #1;
    total++;
    if (sym_out !== 10'b1101010100) begin
      bad++;
      $display("FAIL R2 output moved before edge: got %b expected %b", sym_out, 10'b1101010100);
    end
    mt = 0;
    step(8'hFF, 2'b00, 1'b1, 1'b0, "R2 one-cycle latency");
  endtask

  task automatic t_control_codes();
    for (int c = 0; c < 4; c++) step(8'h77, 2'(c), 1'b0, 1'b0, "R8 control code");
    step(8'h01, 2'b00, 1'b1, 1'b0, "R3 first stage after blank");
    step(8'h01, 2'b00, 1'b1, 1'b0, "R6 main-path choice");
    step(8'h44, 2'b01, 1'b0, 1'b0, "R8 blank clears count");
    step(8'h01, 2'b00, 1'b1, 1'b0, "R5 zero-count path after clear");
  endtask

  task automatic t_worked_case();
    step(8'h00, 2'b00, 1'b0, 1'b0, "R8 blank before worked case");
    step(8'h09, 2'b00, 1'b1, 1'b0, "R5 count to -2");
    check("R9 model count -2", 10'(mt), 10'(-2));
    step(8'h0F, 2'b00, 1'b1, 1'b0, "R9 worked symbol");
    check("R9 symbol literal", sym_out, 10'b1111111010);
    check("R9 model count +4", 10'(mt), 10'd4);
    step(8'h09, 2'b00, 1'b1, 1'b0, "R9 symbol after +4 count");
  endtask

  task automatic t_first_stage_edges();
    logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'h0F, 8'hF0, 8'h1E, 8'h55, 8'hAA, 8'h78};
    step(8'h00, 2'b00, 1'b0, 1'b0, "R8 blank before edges");
    for (int k = 0; k < 8; k++) step(pats[k], 2'b00, 1'b1, 1'b0, "R3 tie and extreme bytes");
  endtask

  task automatic t_random_stream();
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] b;
      logic [1:0] c;
      bit en;
      b = 8'($urandom);
      c = 2'($urandom);
      en = ($urandom % 16) != 0;
      step(b, c, en, 1'b0, "R6 random stream");
      total++;
      if (mt < -10 || mt > 10 || (mt % 2) != 0) begin
        bad++;
        $display("FAIL R7 count out of range: got %0d expected -10..10 even", mt);
      end
    end
  endtask

  task automatic t_reset_collision();
    for (int k = 0; k < 6; k++) step(8'h01 + 8'(k), 2'b00, 1'b1, 1'b0, "R6 build count");
    step(8'hC3, 2'b11, 1'b0, 1'b1, "R1 reset with blank and ctl 11");
    step(8'h01, 2'b00, 1'b1, 1'b0, "R1 count zero after reset");
    for (int k = 0; k < 6; k++) step(8'hE0 ^ 8'(k), 2'b00, 1'b1, 1'b0, "R7 build count again");
    step(8'h81, 2'b00, 1'b1, 1'b1, "R1 reset mid-video");
    step(8'h81, 2'b00, 1'b1, 1'b0, "R5 video after reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_latency();
    t_control_codes();
    t_worked_case();
    t_first_stage_edges();
    t_random_stream();
    t_reset_collision();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule